// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block carries out the state changes a processor core makes when it takes a trap. A trap request comes in with an interrupt flag and a cause code. It is sampled together with the current program counter, the faulting address, the current privilege level and the current interrupt-enable bits. The block decides whether the trap goes to the supervisor handler or the machine handler. It then records the cause, the exception PC and the trap value for that mode, stacks the interrupt-enable and privilege state, computes the handler address, and switches privilege.

Delegation settings and the two handler vector bases are inputs from the surrounding control-register file. The block does not read or write them. It also handles two pieces of cause rewriting. A single environment-call code is turned into a code that depends on the privilege. A translation-failure request is turned into a page fault or an access fault, depending on whether paging is on and on the kind of access. All outputs are registers. Every field changes on the clock edge that samples the request.

Top module: `trap_entry`

## Requirements
- R1: After reset, every cause, exception-PC, trap-value and stacked-status output is zero, `pc_q` is zero, `priv_q` is 3 (machine) and both enable-clear pulses are low.
- R2: A trap goes to supervisor (`priv_q`=1) when `cur_priv` is 0 (user) or 1 (supervisor), the final cause code is below 32, and that code's bit is set in `ideleg` (for interrupts) or `edeleg` (for exceptions). Any other trap goes to machine (`priv_q`=3).
- R3: On a machine trap, `mpie_q` takes `cur_mie`, `mpp_q` takes `cur_priv` and `ie_clr_m` pulses for one cycle. On a supervisor trap, `spie_q` takes `cur_sie`, `spp_q` takes bit 0 of `cur_priv` and `ie_clr_s` pulses for one cycle. The other mode's fields are untouched.
- R4: The target mode's cause register gets the final cause code in its low bits, with bit 31 equal to `trap_async`.
- R5: `pc_q` is the target vector base with bits 1:0 cleared. Only when the trap is an interrupt and the base's bits 1:0 equal 01, four times the cause code is added.
- R6: The target trap-value register gets `fault_addr` for exceptions with final cause 0, 1, 4, 5, 6, 7, 12, 13 or 15, and zero for every other exception and for all interrupts.
- R7: The target exception-PC register gets `cur_pc`.
- R8: An exception with code 8 is an environment call. It is recorded as 8, 9 or 11 when `cur_priv` is 0, 1 or 3.
- R9: An exception with `xlat_fail` set ignores `trap_code`. With `paging_on` it becomes 12, 13 or 15, and without paging it becomes 1, 5 or 7, for `xlat_kind` 0 (fetch), 1 (load) or 2 (store).
- R10: With `trap_req` low, every output register keeps its value whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_async | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | 6 | Raw cause code |
| xlat_fail | input | 1 | Exception is an address-translation failure |
| xlat_kind | input | 2 | 0 fetch, 1 load, 2 store |
| paging_on | input | 1 | Paging enabled (not bare mode) |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| cur_pc | input | 32 | PC of the trapping instruction |
| fault_addr | input | 32 | Faulting address |
| cur_mie | input | 1 | Current machine interrupt enable |
| cur_sie | input | 1 | Current supervisor interrupt enable |
| edeleg | input | 32 | Exception delegation mask |
| ideleg | input | 32 | Interrupt delegation mask |
| svec | input | 32 | Supervisor vector base and mode |
| mvec | input | 32 | Machine vector base and mode |
| priv_q | output | 2 | Privilege after the trap |
| pc_q | output | 32 | Handler address |
| mcause_q | output | 32 | Machine cause |
| mepc_q | output | 32 | Machine exception PC |
| mtval_q | output | 32 | Machine trap value |
| scause_q | output | 32 | Supervisor cause |
| sepc_q | output | 32 | Supervisor exception PC |
| stval_q | output | 32 | Supervisor trap value |
| mpie_q | output | 1 | Machine previous enable |
| mpp_q | output | 2 | Machine previous privilege |
| spie_q | output | 1 | Supervisor previous enable |
| spp_q | output | 1 | Supervisor previous privilege |
| ie_clr_m | output | 1 | One-cycle pulse: clear machine interrupt enable |
| ie_clr_s | output | 1 | One-cycle pulse: clear supervisor interrupt enable |

## Verification
The trap path is driven from each privilege level with the delegation bit both set and clear, so that routing by privilege can be told apart from routing by mask. Interrupts and exceptions are sent with the same code, which separates the two delegation masks, the vectored offset and the address-only trap value. Environment calls and translation failures are sent from every privilege level and every access kind, with paging on and off, to pin down the rewriting of the cause. A code of 32 or above checks the range limit on delegation. A machine vector base in mode 2, and another in mode 1, show that only mode 1 adds the offset.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int XLEN = 32,
  parameter int CW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_req,
  input  logic            trap_async,
  input  logic [CW-1:0]   trap_code,
  input  logic            xlat_fail,
  input  logic [1:0]      xlat_kind,
  input  logic            paging_on,
  input  logic [1:0]      cur_priv,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] fault_addr,
  input  logic            cur_mie,
  input  logic            cur_sie,
  input  logic [XLEN-1:0] edeleg,
  input  logic [XLEN-1:0] ideleg,
  input  logic [XLEN-1:0] svec,
  input  logic [XLEN-1:0] mvec,
  output logic [1:0]      priv_q,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] mcause_q,
  output logic [XLEN-1:0] mepc_q,
  output logic [XLEN-1:0] mtval_q,
  output logic [XLEN-1:0] scause_q,
  output logic [XLEN-1:0] sepc_q,
  output logic [XLEN-1:0] stval_q,
  output logic            mpie_q,
  output logic [1:0]      mpp_q,
  output logic            spie_q,
  output logic            spp_q,
  output logic            ie_clr_m,
  output logic            ie_clr_s
);
  localparam int          IW      = $clog2(XLEN);
  localparam logic [15:0] ADDR_MASK = 16'hB0F3;
  localparam logic [CW-1:0] ECALL = CW'(8);

  logic [CW-1:0]   code;
  logic [XLEN-1:0] deleg, base, cause_w, tval_w, npc;
  logic            to_s, vect, has_addr;

  always_comb begin
    code = trap_code;
    if (!trap_async) begin
      if (xlat_fail) begin
        case (xlat_kind)
          2'd0:    code = paging_on ? CW'(12) : CW'(1);
          2'd1:    code = paging_on ? CW'(13) : CW'(5);
          default: code = paging_on ? CW'(15) : CW'(7);
        endcase
      end else if (trap_code == ECALL) begin
        code = ECALL + CW'(cur_priv);
      end
    end
  end

  assign deleg    = trap_async ? ideleg : edeleg;
  assign to_s     = (cur_priv <= 2'd1) && (code < CW'(XLEN)) && deleg[code[IW-1:0]];
  assign cause_w  = {trap_async, {(XLEN-1-CW){1'b0}}, code};
  assign has_addr = !trap_async && (code < CW'(16)) && ADDR_MASK[code[3:0]];
  assign tval_w   = has_addr ? fault_addr : '0;
  assign base     = to_s ? svec : mvec;
  assign vect     = trap_async && (base[1:0] == 2'b01);
  assign npc      = {base[XLEN-1:2], 2'b00} + (vect ? XLEN'({code, 2'b00}) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q   <= 2'd3;
      pc_q     <= '0;
      mcause_q <= '0;
      mepc_q   <= '0;
      mtval_q  <= '0;
      scause_q <= '0;
      sepc_q   <= '0;
      stval_q  <= '0;
      mpie_q   <= 1'b0;
      mpp_q    <= 2'd0;
      spie_q   <= 1'b0;
      spp_q    <= 1'b0;
      ie_clr_m <= 1'b0;
      ie_clr_s <= 1'b0;
    end else begin
      ie_clr_m <= trap_req && !to_s;
      ie_clr_s <= trap_req && to_s;
      if (trap_req) begin
        pc_q <= npc;
        if (to_s) begin
          priv_q   <= 2'd1;
          scause_q <= cause_w;
          sepc_q   <= cur_pc;
          stval_q  <= tval_w;
          spie_q   <= cur_sie;
          spp_q    <= cur_priv[0];
        end else begin
          priv_q   <= 2'd3;
          mcause_q <= cause_w;
          mepc_q   <= cur_pc;
          mtval_q  <= tval_w;
          mpie_q   <= cur_mie;
          mpp_q    <= cur_priv;
        end
      end
    end
  end

  p_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> (priv_q == 2'd1 || priv_q == 2'd3));

  p_mach_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && cur_priv == 2'd3) |=> (priv_q == 2'd3 && ie_clr_m));

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ie_clr_m, ie_clr_s}));

  p_async_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ((priv_q == 2'd3 ? mcause_q[XLEN-1] : scause_q[XLEN-1]) == $past(trap_async)));

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !trap_async) |=> (pc_q[1:0] == 2'b00));

  p_epc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> ((priv_q == 2'd3 ? mepc_q : sepc_q) == $past(cur_pc)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> ($stable(pc_q) && $stable(priv_q) && $stable(mcause_q) && $stable(scause_q)
                   && $stable(mtval_q) && $stable(stval_q) && !ie_clr_m && !ie_clr_s));
endmodule

// File: tb/trap_entry_tb_top.sv
`timescale 1ns/1ps
module trap_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trap_req = 1'b0, trap_async = 1'b0, xlat_fail = 1'b0, paging_on = 1'b0;
  logic [5:0]  trap_code = '0;
  logic [1:0]  xlat_kind = '0, cur_priv = '0;
  logic [31:0] cur_pc = '0, fault_addr = 32'hDEAD_BEE0;
  logic        cur_mie = 1'b0, cur_sie = 1'b0;
  logic [31:0] edeleg = 32'h0000_3104, ideleg = 32'h0000_0022;
  logic [31:0] svec = 32'h8000_1001, mvec = 32'h0000_4002;
  logic [1:0]  priv_q, mpp_q;
  logic [31:0] pc_q, mcause_q, mepc_q, mtval_q, scause_q, sepc_q, stval_q;
  logic        mpie_q, spie_q, spp_q, ie_clr_m, ie_clr_s;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  trap_entry dut_i (.*);

  typedef struct packed {
    logic        as;
    logic [5:0]  code;
    logic        xf;
    logic [1:0]  kind;
    logic        pg;
    logic [1:0]  pr;
    logic [1:0]  epr;
    logic [31:0] ecause;
    logic [31:0] epc;
    logic        etv;
  } vec_t;

  localparam vec_t VECS [17] = '{
    '{1'b0, 6'd2,  1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 32'd2,         32'h8000_1000, 1'b0},
    '{1'b0, 6'd2,  1'b0, 2'd0, 1'b0, 2'd3, 2'd3, 32'd2,         32'h0000_4000, 1'b0},
    '{1'b0, 6'd8,  1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 32'd8,         32'h8000_1000, 1'b0},
    '{1'b0, 6'd8,  1'b0, 2'd0, 1'b0, 2'd1, 2'd3, 32'd9,         32'h0000_4000, 1'b0},
    '{1'b0, 6'd8,  1'b0, 2'd0, 1'b0, 2'd3, 2'd3, 32'd11,        32'h0000_4000, 1'b0},
    '{1'b1, 6'd5,  1'b0, 2'd0, 1'b0, 2'd1, 2'd1, 32'h8000_0005, 32'h8000_1014, 1'b0},
    '{1'b1, 6'd3,  1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 32'h8000_0003, 32'h0000_4000, 1'b0},
    '{1'b1, 6'd5,  1'b0, 2'd0, 1'b0, 2'd3, 2'd3, 32'h8000_0005, 32'h0000_4000, 1'b0},
    '{1'b0, 6'd13, 1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 32'd13,        32'h8000_1000, 1'b1},
    '{1'b0, 6'd5,  1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 32'd5,         32'h0000_4000, 1'b1},
    '{1'b0, 6'd2,  1'b1, 2'd0, 1'b1, 2'd0, 2'd1, 32'd12,        32'h8000_1000, 1'b1},
    '{1'b0, 6'd2,  1'b1, 2'd2, 1'b1, 2'd0, 2'd3, 32'd15,        32'h0000_4000, 1'b1},
    '{1'b0, 6'd2,  1'b1, 2'd1, 1'b0, 2'd1, 2'd3, 32'd5,         32'h0000_4000, 1'b1},
    '{1'b0, 6'd8,  1'b1, 2'd0, 1'b0, 2'd3, 2'd3, 32'd1,         32'h0000_4000, 1'b1},
    '{1'b0, 6'd40, 1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 32'd40,        32'h0000_4000, 1'b0},
    '{1'b1, 6'd1,  1'b0, 2'd0, 1'b0, 2'd0, 2'd1, 32'h8000_0001, 32'h8000_1004, 1'b0},
    '{1'b0, 6'd3,  1'b0, 2'd0, 1'b0, 2'd0, 2'd3, 32'd3,         32'h0000_4000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic take_trap();
    @(negedge clk) trap_req = 1'b1;
    @(posedge clk) #1;
    trap_req = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] o_cause, o_epc, o_tval;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 priv", {30'd0, priv_q}, 32'd3);
    chk("R1 pc", pc_q, 32'd0);
    chk("R1 regs", mcause_q | mepc_q | mtval_q | scause_q | sepc_q | stval_q, 32'd0);
    chk("R1 status", {26'd0, mpie_q, mpp_q, spie_q, spp_q, ie_clr_m | ie_clr_s}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 17; i++) begin
      vec_t v = VECS[i];
      @(negedge clk);
      trap_async = v.as; trap_code = v.code; xlat_fail = v.xf; xlat_kind = v.kind;
      paging_on = v.pg; cur_priv = v.pr; cur_pc = 32'h1000_0000 + 32'(i * 4);
      cur_mie = i[0]; cur_sie = i[1];
      o_cause = (v.epr == 2'd1) ? mcause_q : scause_q;
      o_epc   = (v.epr == 2'd1) ? mepc_q : sepc_q;
      o_tval  = (v.epr == 2'd1) ? mtval_q : stval_q;
      take_trap();
      chk($sformatf("R2 vec%0d priv", i), {30'd0, priv_q}, {30'd0, v.epr});
      chk($sformatf("R5 vec%0d pc", i), pc_q, v.epc);
      if (v.epr == 2'd1) begin
        chk($sformatf("R4 R8 R9 vec%0d scause", i), scause_q, v.ecause);
        chk($sformatf("R7 vec%0d sepc", i), sepc_q, cur_pc);
        chk($sformatf("R6 vec%0d stval", i), stval_q, v.etv ? fault_addr : 32'd0);
        chk($sformatf("R3 vec%0d sstack", i), {29'd0, spie_q, spp_q, ie_clr_s}, {29'd0, cur_sie, cur_priv[0], 1'b1});
        chk($sformatf("R3 vec%0d m untouched", i), mcause_q ^ mepc_q ^ mtval_q, o_cause ^ o_epc ^ o_tval);
      end else begin
        chk($sformatf("R4 R8 R9 vec%0d mcause", i), mcause_q, v.ecause);
        chk($sformatf("R7 vec%0d mepc", i), mepc_q, cur_pc);
        chk($sformatf("R6 vec%0d mtval", i), mtval_q, v.etv ? fault_addr : 32'd0);
        chk($sformatf("R3 vec%0d mstack", i), {28'd0, mpie_q, mpp_q, ie_clr_m}, {28'd0, cur_mie, cur_priv, 1'b1});
        chk($sformatf("R3 vec%0d s untouched", i), scause_q ^ sepc_q ^ stval_q, o_cause ^ o_epc ^ o_tval);
      end
      @(posedge clk) #1;
      chk($sformatf("R3 vec%0d pulse ends", i), {30'd0, ie_clr_m, ie_clr_s}, 32'd0);
    end

    // R5: machine vector in mode 1, interrupt 7 -> base + 28
    @(negedge clk);
    mvec = 32'h0000_6001; trap_async = 1'b1; trap_code = 6'd7; cur_priv = 2'd3; xlat_fail = 1'b0;
    take_trap();
    chk("R5 vectored machine pc", pc_q, 32'h0000_601C);
    // R5: same base, exception 7 -> no offset
    @(negedge clk) trap_async = 1'b0;
    take_trap();
    chk("R5 vectored base exception pc", pc_q, 32'h0000_6000);

    // R10: inputs churn without a request
    begin
      logic [31:0] s_pc, s_mc, s_sc, s_mt;
      logic [1:0]  s_pr;
      s_pc = pc_q; s_mc = mcause_q; s_sc = scause_q; s_mt = mtval_q; s_pr = priv_q;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        trap_async = k[0]; trap_code = 6'(k * 3); cur_priv = k[1:0]; cur_pc = 32'(k * 77);
        fault_addr = ~fault_addr; mvec = mvec + 32'h100;
      end
      @(posedge clk) #1;
      chk("R10 pc held", pc_q, s_pc);
      chk("R10 mcause held", mcause_q, s_mc);
      chk("R10 scause held", scause_q, s_sc);
      chk("R10 mtval held", mtval_q, s_mt);
      chk("R10 priv held", {30'd0, priv_q}, {30'd0, s_pr});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule